// File: doc/BRIEF.md
# Debug Halt Entry Controller

This block decides when a processor core stops running and enters debug mode, and it tells an external debug host that the halt has happened. Several things can ask for a halt:

- the host's debug-request line,
- a software debug instruction whose condition holds,
- a trace counter that has reached zero.

Each of these arms the controller. The core then keeps running until the next instruction reaches its instruction latch, and the controller halts it there. If the host holds its request while reset is applied, the core never runs at all. It goes from reset straight into debug mode.

A core sitting in its stop or wait low-power state cannot reach an instruction latch on its own. While a request is pending, the controller raises a wake-up line so the core resumes and fetches. When debug mode begins, the controller drives the active-low acknowledge line low for one clock.

After entry, a command-start indication from the host is passed on only once the host has dropped its request. This follows the rule that the request must be released before the first command.

The state machine has six states:

- BOOT: held while reset is sampled.
- RUN: idle, no request pending.
- ARMED: a request is pending and the controller is waiting for a latch strobe.
- ENTER: the single acknowledge cycle.
- HELD: in debug mode, with the request still high.
- READY: in debug mode, with the request released.

Its transitions are:

- BOOT goes to ENTER if a request was captured during reset, and to RUN otherwise.
- RUN goes to ARMED on any merged entry event.
- ARMED goes to ENTER on a latch strobe.
- ENTER goes to HELD or READY, depending on the request line.
- HELD goes to READY once the request falls.
- READY is kept until reset.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: While `rst_n` is sampled low, the controller is in BOOT. In BOOT, `halt_o`=1, `dso_n_o`=1, `dbg_mode_o`=0, `wake_o`=0 and `cmd_go_o`=0.
- R2: If `dbg_req_i` is high at the last rising edge with `rst_n` low, the first edge with `rst_n` high enters debug mode directly. No latch strobe is needed and `halt_o` never drops. This path takes priority over every other entry source.
- R3: In RUN, `dbg_req_i`=1 arms the controller. Entry happens on the first `latch_i` strobe sampled at an edge later than the arming edge. A strobe in the same cycle as the request does not count.
- R4: While armed, `wake_o` is 1 if `core_state_i` is 2'b01 (stop) or 2'b10 (wait), and 0 if it is 2'b00 (run). Entry still waits for the next latch strobe.
- R5: `sw_dbg_i`=1 together with `sw_cond_i`=1 arms the controller in RUN. `sw_dbg_i` with `sw_cond_i`=0 has no effect.
- R6: `trace_zero_i`=1 in RUN arms the controller in the same way.
- R7: Entry sources that occur in the same cycle, or while already armed, merge into one entry and one acknowledge.
- R8: `dso_n_o` goes low for exactly one cycle, the first cycle in which `dbg_mode_o` is 1, and at no other time.
- R9: Once `dbg_mode_o` is 1, it and `halt_o` stay 1 until reset. Further entry events cause no further acknowledge.
- R10: `cmd_go_o` equals `cmd_start_i` only in debug mode, after `dbg_req_i` has been sampled low at some edge since entry, and only while `dbg_req_i` is low. In every other case it is 0.
- R11: While armed, `halt_o` and `dbg_mode_o` stay 0 so the core can run up to the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_req_i | input | 1 | Debug request from the external host |
| core_state_i | input | 2 | Core activity: 00 run, 01 stop, 10 wait, 11 treated as run |
| sw_dbg_i | input | 1 | Software debug instruction executed |
| sw_cond_i | input | 1 | Condition result of that instruction (1 for unconditional) |
| trace_zero_i | input | 1 | Trace counter reached zero |
| latch_i | input | 1 | An instruction entered the instruction latch |
| cmd_start_i | input | 1 | Host command-start indication |
| halt_o | output | 1 | Core must not execute |
| dso_n_o | output | 1 | Active-low one-cycle acknowledge of debug entry |
| dbg_mode_o | output | 1 | Core is in debug mode |
| wake_o | output | 1 | Wake the core from stop or wait so it can fetch |
| cmd_go_o | output | 1 | Qualified command start forwarded to the debug logic |

## Verification
Two pairs of functions can land in the same cycle, and both are provoked directly.

The first pair is the arming request and the latch strobe. The bench raises the request and a latch strobe on the same edge, and expects the controller to arm without entering. It then expects entry on the next strobe.

The second pair is reset-time entry and the run-time sources. The bench holds the request, software debug and trace-zero together through reset release, and expects a direct ENTER followed by HELD, never ARMED. It also raises all three run-time sources together, and repeats them after entry, and requires exactly one low cycle on the acknowledge line.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

    // Width of the core activity code and of the merged source vector.
    localparam int CORE_ST_W = 2;
    localparam int NUM_SRC   = 3;

    typedef enum logic [CORE_ST_W-1:0] {
        CORE_RUN  = 2'b00,
        CORE_STOP = 2'b01,
        CORE_WAIT = 2'b10,
        CORE_RSVD = 2'b11
    } core_st_e;

    typedef enum logic [2:0] {
        ST_BOOT  = 3'd0,
        ST_RUN   = 3'd1,
        ST_ARMED = 3'd2,
        ST_ENTER = 3'd3,
        ST_HELD  = 3'd4,
        ST_READY = 3'd5
    } dbg_st_e;

endpackage

// File: rtl/dbg_req_merge.sv
module dbg_req_merge
    import dbg_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dbg_req_i,
    input  logic sw_dbg_i,
    input  logic sw_cond_i,
    input  logic trace_zero_i,
    output logic boot_req_o,
    output logic run_evt_o
);

    logic [NUM_SRC-1:0] src_vec;
    logic               boot_req_q;

    // Index 0: host request, 1: qualified software request, 2: trace zero.
    assign src_vec[0] = dbg_req_i;
    assign src_vec[1] = sw_dbg_i & sw_cond_i;
    assign src_vec[2] = trace_zero_i;

    // All run-time sources collapse into one entry event.
    assign run_evt_o = |src_vec;

    // The host request is sampled on every reset edge.
    // The last sample before release decides direct entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_req_q <= dbg_req_i;
        end else begin
            boot_req_q <= 1'b0;
        end
    end

    assign boot_req_o = boot_req_q;

endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
    import dbg_entry_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    boot_req_i,
    input  logic    run_evt_i,
    input  logic    latch_i,
    input  logic    dbg_req_i,
    output dbg_st_e state_o,
    output logic    enter_next_o
);

    dbg_st_e state_q;
    dbg_st_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = boot_req_i ? ST_ENTER : ST_RUN;
            ST_RUN:   state_d = run_evt_i  ? ST_ARMED : ST_RUN;
            ST_ARMED: state_d = latch_i    ? ST_ENTER : ST_ARMED;
            ST_ENTER: state_d = dbg_req_i  ? ST_HELD  : ST_READY;
            ST_HELD:  state_d = dbg_req_i  ? ST_HELD  : ST_READY;
            ST_READY: state_d = ST_READY;
            default:  state_d = ST_BOOT;
        endcase
    end

    assign state_o      = state_q;
    assign enter_next_o = rst_n && (state_d == ST_ENTER);

    // Armed without a latch strobe stays armed.
    assert_wait_for_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !latch_i) |=> (state_q == ST_ARMED));

    // A request captured in reset leads straight to the acknowledge state.
    assert_boot_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT && boot_req_i) |=> (state_q == ST_ENTER));

    // READY is reached only after the request was seen low.
    assert_ready_after_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_READY) |-> !$past(dbg_req_i));

    // Once in debug mode the machine never returns to a running state.
    assert_debug_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD || state_q == ST_READY) |=>
        (state_q == ST_HELD || state_q == ST_READY));

endmodule

// File: rtl/dbg_ack_pulse.sv
module dbg_ack_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_next_i,
    output logic dso_n_o
);

    logic ack_n_q;

    // Registered from the next state, so the low cycle lines up with ENTER.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_n_q <= 1'b1;
        end else begin
            ack_n_q <= ~enter_next_i;
        end
    end

    assign dso_n_o = ack_n_q;

    assert_ack_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dso_n_o |=> dso_n_o);

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_entry_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dbg_req_i,
    input  logic [CORE_ST_W-1:0] core_state_i,
    input  logic                 sw_dbg_i,
    input  logic                 sw_cond_i,
    input  logic                 trace_zero_i,
    input  logic                 latch_i,
    input  logic                 cmd_start_i,
    output logic                 halt_o,
    output logic                 dso_n_o,
    output logic                 dbg_mode_o,
    output logic                 wake_o,
    output logic                 cmd_go_o
);

    logic    boot_req;
    logic    run_evt;
    logic    enter_next;
    logic    core_idle;
    dbg_st_e state;

    dbg_req_merge u_merge (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_req_i    (dbg_req_i),
        .sw_dbg_i     (sw_dbg_i),
        .sw_cond_i    (sw_cond_i),
        .trace_zero_i (trace_zero_i),
        .boot_req_o   (boot_req),
        .run_evt_o    (run_evt)
    );

    dbg_entry_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_req_i   (boot_req),
        .run_evt_i    (run_evt),
        .latch_i      (latch_i),
        .dbg_req_i    (dbg_req_i),
        .state_o      (state),
        .enter_next_o (enter_next)
    );

    dbg_ack_pulse u_ack (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_next_i (enter_next),
        .dso_n_o      (dso_n_o)
    );

    // Stop and wait are the only low-power codes; the reserved code counts as run.
    assign core_idle = (core_state_i == CORE_STOP) || (core_state_i == CORE_WAIT);

    // Output decode
    always_comb begin
        halt_o     = 1'b0;
        dbg_mode_o = 1'b0;
        wake_o     = 1'b0;
        cmd_go_o   = 1'b0;
        unique case (state)
            ST_BOOT: begin
                halt_o = 1'b1;
            end
            ST_RUN: begin
                halt_o = 1'b0;
            end
            ST_ARMED: begin
                wake_o = core_idle;
            end
            ST_ENTER, ST_HELD: begin
                halt_o     = 1'b1;
                dbg_mode_o = 1'b1;
            end
            ST_READY: begin
                halt_o     = 1'b1;
                dbg_mode_o = 1'b1;
                cmd_go_o   = cmd_start_i & ~dbg_req_i;
            end
            default: begin
                halt_o = 1'b1;
            end
        endcase
    end

    // The acknowledge only marks the first debug cycle.
    assert_ack_marks_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dso_n_o |-> (dbg_mode_o && !$past(dbg_mode_o)));

    // Halt never drops while the request captured in reset is pending.
    assert_boot_no_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        boot_req |-> halt_o);

    // Wake-up is only given while the core is allowed to run.
    assert_wake_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (!halt_o && !dbg_mode_o && dso_n_o));

    // A forwarded command implies debug mode and a released request.
    assert_cmd_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go_o |-> (dbg_mode_o && dso_n_o && !$past(dbg_req_i)));

endmodule

// File: tb/dbg_entry_ctrl_test.sv
module dbg_entry_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dbg_req_i = 1'b0;
    logic [1:0] core_state_i = 2'b00;
    logic       sw_dbg_i = 1'b0;
    logic       sw_cond_i = 1'b0;
    logic       trace_zero_i = 1'b0;
    logic       latch_i = 1'b0;
    logic       cmd_start_i = 1'b0;
    logic       halt_o, dso_n_o, dbg_mode_o, wake_o, cmd_go_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    // Expected output vector, bit order {halt, dso_n, dbg_mode, wake, cmd_go}.
    localparam logic [4:0] E_BOOT = 5'b11000;
    localparam logic [4:0] E_RUN  = 5'b01000;
    localparam logic [4:0] E_ARM  = 5'b01000;
    localparam logic [4:0] E_ARMW = 5'b01010;
    localparam logic [4:0] E_ENT  = 5'b10100;
    localparam logic [4:0] E_DBG  = 5'b11100;
    localparam logic [4:0] E_GO   = 5'b11101;

    always #10 clk = ~clk;

    dbg_entry_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_req_i    (dbg_req_i),
        .core_state_i (core_state_i),
        .sw_dbg_i     (sw_dbg_i),
        .sw_cond_i    (sw_cond_i),
        .trace_zero_i (trace_zero_i),
        .latch_i      (latch_i),
        .cmd_start_i  (cmd_start_i),
        .halt_o       (halt_o),
        .dso_n_o      (dso_n_o),
        .dbg_mode_o   (dbg_mode_o),
        .wake_o       (wake_o),
        .cmd_go_o     (cmd_go_o)
    );

    // Driver: drives inputs at the falling edge and queues the outputs
    // expected after the following rising edge.
    task automatic step(input logic r, input logic q, input logic [1:0] cs,
                        input logic s, input logic c, input logic t,
                        input logic l, input logic k,
                        input logic [4:0] e, input string tag);
        @(negedge clk);
        rst_n        = r;
        dbg_req_i    = q;
        core_state_i = cs;
        sw_dbg_i     = s;
        sw_cond_i    = c;
        trace_zero_i = t;
        latch_i      = l;
        cmd_start_i  = k;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic reset_run();
        step(0, 0, 2'b00, 0, 0, 0, 0, 0, E_BOOT, "R1 boot in reset");
        step(0, 0, 2'b00, 0, 0, 0, 0, 0, E_BOOT, "R1 boot in reset");
        step(1, 0, 2'b00, 0, 0, 0, 0, 0, E_RUN,  "R1 run after release");
    endtask

    // Monitor: samples a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [4:0] e;
                logic [4:0] a;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {halt_o, dso_n_o, dbg_mode_o, wake_o, cmd_go_o};
                compared++;
                if (a !== e) begin
                    mismatched++;
                    $display("FAIL %s: actual %b expected %b (halt,dso_n,dbg,wake,go)", t, a, e);
                end
            end
        end
    end

    initial begin
        // Reset state, then direct entry with the request held through reset.
        step(0, 1, 2'b00, 0, 0, 0, 0, 0, E_BOOT, "R1 boot with request");
        step(0, 1, 2'b00, 0, 0, 0, 0, 0, E_BOOT, "R1 boot with request");
        step(1, 1, 2'b00, 0, 0, 0, 0, 0, E_ENT,  "R2 direct entry R8 ack");
        step(1, 1, 2'b00, 0, 0, 0, 0, 1, E_DBG,  "R10 command ignored while request held");
        step(1, 1, 2'b00, 0, 0, 0, 0, 1, E_DBG,  "R10 command ignored while request held");
        step(1, 0, 2'b00, 0, 0, 0, 0, 0, E_DBG,  "R9 debug after release");
        step(1, 0, 2'b00, 0, 0, 0, 0, 1, E_GO,   "R10 command forwarded");
        step(1, 1, 2'b00, 0, 0, 0, 0, 1, E_DBG,  "R10 command gated by request");
        step(1, 0, 2'b00, 0, 0, 1, 0, 0, E_DBG,  "R9 no second ack");

        // Host request during run, with a latch strobe in the same cycle.
        reset_run();
        step(1, 0, 2'b00, 0, 0, 0, 0, 1, E_RUN,  "R10 no command outside debug");
        step(1, 1, 2'b00, 0, 0, 0, 1, 0, E_ARM,  "R3 same-cycle latch ignored R11");
        step(1, 1, 2'b00, 0, 0, 0, 0, 0, E_ARM,  "R3 armed waiting R11");
        step(1, 1, 2'b00, 0, 0, 0, 1, 0, E_ENT,  "R3 entry on latch R8");
        step(1, 0, 2'b00, 0, 0, 0, 0, 0, E_DBG,  "R8 ack single cycle");
        step(1, 0, 2'b00, 0, 0, 0, 0, 1, E_GO,   "R10 command after release");

        // Request while the core is in stop.
        reset_run();
        step(1, 1, 2'b01, 0, 0, 0, 0, 0, E_ARMW, "R4 wake from stop");
        step(1, 1, 2'b01, 0, 0, 0, 0, 0, E_ARMW, "R4 wake held");
        step(1, 1, 2'b00, 0, 0, 0, 0, 0, E_ARM,  "R4 woken core runs R11");
        step(1, 1, 2'b00, 0, 0, 0, 1, 0, E_ENT,  "R4 entry after latch");
        step(1, 0, 2'b00, 0, 0, 0, 0, 0, E_DBG,  "R4 debug");

        // Request while the core is in wait.
        reset_run();
        step(1, 1, 2'b10, 0, 0, 0, 0, 0, E_ARMW, "R4 wake from wait");
        step(1, 1, 2'b10, 0, 0, 0, 1, 0, E_ENT,  "R4 entry after latch in wait");
        step(1, 1, 2'b10, 0, 0, 0, 0, 0, E_DBG,  "R4 no wake in debug");

        // Software request with its condition false, then true.
        reset_run();
        step(1, 0, 2'b00, 1, 0, 0, 0, 0, E_RUN,  "R5 false condition");
        step(1, 0, 2'b00, 0, 0, 0, 1, 0, E_RUN,  "R5 false condition not armed");
        step(1, 0, 2'b00, 1, 1, 0, 0, 0, E_ARM,  "R5 software arms");
        step(1, 0, 2'b00, 0, 0, 0, 1, 0, E_ENT,  "R5 entry after next latch");
        step(1, 0, 2'b00, 0, 0, 0, 0, 1, E_GO,   "R10 command without host request");

        // Trace counter zero.
        reset_run();
        step(1, 0, 2'b00, 0, 0, 1, 0, 0, E_ARM,  "R6 trace arms");
        step(1, 0, 2'b00, 0, 0, 0, 0, 0, E_ARM,  "R6 armed");
        step(1, 0, 2'b00, 0, 0, 0, 1, 0, E_ENT,  "R6 entry");
        step(1, 0, 2'b00, 0, 0, 0, 0, 0, E_DBG,  "R6 debug");

        // All run-time sources together.
        reset_run();
        step(1, 1, 2'b00, 1, 1, 1, 0, 0, E_ARM,  "R7 merged arm");
        step(1, 1, 2'b00, 1, 1, 1, 0, 0, E_ARM,  "R7 merged still armed");
        step(1, 1, 2'b00, 1, 1, 1, 1, 0, E_ENT,  "R7 single entry");
        step(1, 1, 2'b00, 1, 1, 1, 1, 0, E_DBG,  "R7 no second ack");
        step(1, 0, 2'b00, 0, 0, 0, 0, 0, E_DBG,  "R9 stays in debug");
        step(1, 0, 2'b00, 1, 1, 1, 1, 0, E_DBG,  "R9 events ignored in debug");

        // Reset-time request beats the other sources.
        step(0, 1, 2'b00, 1, 1, 1, 0, 0, E_BOOT, "R1 boot all sources");
        step(0, 1, 2'b00, 1, 1, 1, 0, 0, E_BOOT, "R1 boot all sources");
        step(1, 1, 2'b00, 1, 1, 1, 0, 0, E_ENT,  "R2 priority direct entry");
        step(1, 1, 2'b00, 1, 1, 1, 0, 0, E_DBG,  "R2 held not armed");
        step(1, 0, 2'b00, 0, 0, 0, 0, 1, E_GO,   "R10 command after release");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog
    initial begin
        #4000000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule